// File: doc/BRIEF.md
# Two-Channel Staged Copy Engine

This block copies blocks of words from one memory region to another for two independent channels. A copy never goes directly from source to destination. The engine first reads up to 32 bytes from the source as a single read burst and keeps them in an internal staging buffer. It then writes the buffered words to the destination as a single write burst. It repeats this fill-then-drain pair, moving the addresses forward each time, until the programmed byte count reaches zero.

Each channel has a source address, a destination address, a byte count and a control word, all loaded through a simple write-only configuration port. Software can start a channel with one control write that sets both the enable and the go bit. An external device can also start it with a rising edge on its request line, but only when software has already set the enable bit. When a channel finishes it raises a sticky done flag. Both channels share one burst memory port. Channel 0 has fixed priority, and a channel that holds the port keeps it until its current fill and drain pair is complete.

Top module: `dma2ch_top`

## Requirements
- R1: `cfg_addr` is split as {channel, register}. Bit 2 selects the channel. Bits 1:0 select the register: 0 source, 1 destination, 2 byte count, 3 control. The two low bits of every written source, destination and count value are dropped, so command addresses are always word aligned.
- R2: A control write with bit 0 (enable) and bit 1 (go) both set starts the channel. A control write with go set but enable clear starts nothing.
- R3: A rising edge on `req_i[c]` starts channel c only if its enable bit is already 1. An edge while enable is 0 causes no memory traffic.
- R4: Each step reads N words from the source as one read burst, then writes those same N words in the same order to the destination as one write burst. After completion the destination holds a copy of the source.
- R5: A step moves 8 words (32 bytes) when at least 32 bytes remain. Otherwise it moves the remaining count divided by 4, and words past the end of the destination block are left untouched.
- R6: After a fill the source address advances by the bytes moved. After a drain the destination address advances by the same amount and the remaining count falls by it, so successive bursts target consecutive 32-byte blocks.
- R7: When both channels are pending, channel 0 gets the port. A channel keeps the port across its fill and its drain and is re-arbitrated only after the drain, so a pending channel 0 runs all its steps before channel 1 starts.
- R8: On completion the channel clears go and sets `done_o[c]`, which stays set until a control write with bit 2 set clears it. A start with a count of 0 sets done without any memory command. `done_o` is 0 after reset.
- R9: While a channel is running, writes to its source, destination, count, enable and go are ignored. The running copy uses the values from the start, and enable keeps its value after completion.
- R10: Once `mem_cmd_valid` is raised, the command's address, direction and beat count stay unchanged until `mem_cmd_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | {channel, register select} |
| cfg_wdata | input | 32 | Configuration write data |
| req_i | input | 2 | Per-channel external start request |
| done_o | output | 2 | Per-channel sticky completion flag |
| mem_cmd_valid | output | 1 | Burst command valid |
| mem_cmd_ready | input | 1 | Burst command accepted |
| mem_cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| mem_cmd_addr | output | 32 | Burst start byte address |
| mem_cmd_beats | output | 4 | Burst length in 32-bit words (1 to 8) |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| mem_wvalid | output | 1 | Write data beat valid |
| mem_wready | input | 1 | Write data beat accepted |
| mem_wdata | output | 32 | Write data beat |

## Verification
The assertions assume that the memory side follows the burst protocol. After it accepts a read command it returns exactly the requested number of `mem_rvalid` beats before the next command, and it raises `mem_wready` only during the write burst it accepted. They also assume that request lines are synchronous to `clk` and that the count is never below the bytes of a step. The bench's memory model is built around these rules. Bursts run back to back, and a slow mode delays command acceptance and write-beat acceptance on alternate cycles so that stalled commands and stalled write beats both occur.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int NCH       = 2;
    localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int LEN_W     = 16;
    localparam int BUF_BYTES = 32;
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int BEAT_W    = $clog2(BUF_WORDS + 1);
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int CFG_AW    = CH_W + 2;

    // control word bit positions
    localparam int CTL_EN  = 0;
    localparam int CTL_GO  = 1;
    localparam int CTL_CLR = 2;

    typedef enum logic [1:0] {
        RG_SRC = 2'd0,
        RG_DST = 2'd1,
        RG_LEN = 2'd2,
        RG_CTL = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_CMD,
        S_RD_DATA,
        S_WR_CMD,
        S_WR_DATA
    } eng_state_e;

    typedef struct packed {
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [LEN_W-1:0] rem;
        logic             go;
    } chan_view_t;

    typedef struct packed {
        logic [CH_W-1:0]  sel;
        logic             adv_src;
        logic             adv_dst;
        logic             finish;
        logic [LEN_W-1:0] bytes;
    } eng_ctl_t;

    function automatic logic [BEAT_W-1:0] chunk_words(input logic [LEN_W-1:0] rem);
        if (rem >= LEN_W'(BUF_BYTES))
            return BEAT_W'(BUF_WORDS);
        return BEAT_W'(rem >> 2);
    endfunction

endpackage

// File: rtl/dmx_stage.sv
module dmx_stage
    import dmx_pkg::*;
#(
    parameter int WIDTH = DW,
    parameter int DEPTH = BUF_WORDS,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_idx] <= wr_data;
    end

    assign rd_data = store[rd_idx];

endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
    import dmx_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              req,
    input  eng_ctl_t          ctl,
    output chan_view_t        view,
    output logic              done
);

    logic [AW-1:0]    src_q, dst_q;
    logic [LEN_W-1:0] rem_q;
    logic             en_q, go_q, done_q, req_q;

    logic     hit, mine, ctl_wr, req_edge;
    reg_sel_e rsel;

    assign hit      = cfg_we && (cfg_addr[CFG_AW-1:2] == CH_W'(CH_ID));
    assign rsel     = reg_sel_e'(cfg_addr[1:0]);
    assign ctl_wr   = hit && (rsel == RG_CTL);
    assign mine     = (ctl.sel == CH_W'(CH_ID));
    assign req_edge = req && !req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            rem_q  <= '0;
            en_q   <= 1'b0;
            go_q   <= 1'b0;
            done_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= req;
            if (hit && !go_q) begin
                unique case (rsel)
                    RG_SRC: src_q <= {cfg_wdata[AW-1:2], 2'b00};
                    RG_DST: dst_q <= {cfg_wdata[AW-1:2], 2'b00};
                    RG_LEN: rem_q <= {cfg_wdata[LEN_W-1:2], 2'b00};
                    RG_CTL: begin
                        en_q <= cfg_wdata[CTL_EN];
                        go_q <= cfg_wdata[CTL_EN] & cfg_wdata[CTL_GO];
                    end
                endcase
            end
            if (ctl_wr && cfg_wdata[CTL_CLR])
                done_q <= 1'b0;
            if (req_edge && en_q && !go_q && !ctl_wr)
                go_q <= 1'b1;
            if (mine && ctl.adv_src)
                src_q <= src_q + AW'(ctl.bytes);
            if (mine && ctl.adv_dst) begin
                dst_q <= dst_q + AW'(ctl.bytes);
                rem_q <= rem_q - ctl.bytes;
            end
            if (mine && ctl.finish) begin
                go_q   <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign view.src = src_q;
    assign view.dst = dst_q;
    assign view.rem = rem_q;
    assign view.go  = go_q;
    assign done     = done_q;

    // R2/R3: a running channel always has its enable set
    a_r2_go_needs_en: assert property (@(posedge clk) disable iff (rst)
        go_q |-> en_q);

    // R8: done only rises on a completion from the engine
    a_r8_done_on_finish: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(mine && ctl.finish));

    // R6: the count never steps below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (mine && ctl.adv_dst) |-> (rem_q >= ctl.bytes));

    // R9: while running, the source only moves by engine steps
    a_r9_src_frozen: assert property (@(posedge clk) disable iff (rst)
        (go_q && $past(go_q) && !$past(mine && ctl.adv_src)) |-> $stable(src_q));

endmodule

// File: rtl/dmx_engine.sv
module dmx_engine
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_view_t        views [NCH],
    output eng_ctl_t          ctl,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [AW-1:0]     cmd_addr,
    output logic [BEAT_W-1:0] cmd_beats,
    input  logic              rvalid,
    output logic              wvalid,
    input  logic              wready,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx
);

    eng_state_e        st_q;
    logic [CH_W-1:0]   sel_q, pick;
    logic [BEAT_W-1:0] beats_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              any, last;
    chan_view_t        cur;
    logic [LEN_W-1:0]  step_bytes;

    // fixed priority: lowest channel index wins
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (views[i].go) begin
                any  = 1'b1;
                pick = CH_W'(i);
            end
        end
    end

    assign cur        = views[sel_q];
    assign step_bytes = LEN_W'({beats_q, 2'b00});
    assign last       = ({1'b0, cnt_q} == (beats_q - BEAT_W'(1)));

    assign cmd_valid = (st_q == S_RD_CMD) || (st_q == S_WR_CMD);
    assign cmd_write = (st_q == S_WR_CMD);
    assign cmd_addr  = (st_q == S_WR_CMD) ? cur.dst : cur.src;
    assign cmd_beats = beats_q;
    assign wvalid    = (st_q == S_WR_DATA);
    assign buf_we    = (st_q == S_RD_DATA) && rvalid;
    assign buf_idx   = cnt_q;

    always_comb begin
        ctl         = '0;
        ctl.sel     = (st_q == S_IDLE) ? pick : sel_q;
        ctl.bytes   = step_bytes;
        ctl.adv_src = (st_q == S_RD_DATA) && rvalid && last;
        ctl.adv_dst = (st_q == S_WR_DATA) && wready && last;
        if (st_q == S_IDLE)
            ctl.finish = any && (views[pick].rem == '0);
        else
            ctl.finish = ctl.adv_dst && (cur.rem == step_bytes);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            sel_q   <= '0;
            beats_q <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (any) begin
                        sel_q <= pick;
                        if (views[pick].rem != '0) begin
                            beats_q <= chunk_words(views[pick].rem);
                            st_q    <= S_RD_CMD;
                        end
                    end
                end
                S_RD_CMD: begin
                    cnt_q <= '0;
                    if (cmd_ready)
                        st_q <= S_RD_DATA;
                end
                S_RD_DATA: begin
                    if (rvalid) begin
                        cnt_q <= cnt_q + IDX_W'(1);
                        if (last)
                            st_q <= S_WR_CMD;
                    end
                end
                S_WR_CMD: begin
                    cnt_q <= '0;
                    if (cmd_ready)
                        st_q <= S_WR_DATA;
                end
                S_WR_DATA: begin
                    if (wready) begin
                        cnt_q <= cnt_q + IDX_W'(1);
                        if (last)
                            st_q <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R10: command fields hold while waiting for acceptance
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                       && $stable(cmd_write) && $stable(cmd_beats)));

    // R5: every burst is between one word and a full buffer
    a_r5_beats_range: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_beats != '0) && (cmd_beats <= BEAT_W'(BUF_WORDS)));

    // R1: command addresses are word aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr[1:0] == 2'b00));

    // R7: the owning channel does not change inside a fill/drain pair
    a_r7_owner_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q != S_IDLE) |=> $stable(sel_q));

    // R4: a write burst only follows a complete fill
    a_r4_fill_before_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == S_WR_CMD) |-> $past(ctl.adv_src));

endmodule

// File: rtl/dma2ch_top.sv
module dma2ch_top
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic [NCH-1:0]    req_i,
    output logic [NCH-1:0]    done_o,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic              mem_cmd_write,
    output logic [AW-1:0]     mem_cmd_addr,
    output logic [BEAT_W-1:0] mem_cmd_beats,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [DW-1:0]     mem_wdata
);

    chan_view_t       views [NCH];
    eng_ctl_t         ctl;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmx_chan #(.CH_ID(g)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we),
            .cfg_addr  (cfg_addr),
            .cfg_wdata (cfg_wdata),
            .req       (req_i[g]),
            .ctl       (ctl),
            .view      (views[g]),
            .done      (done_o[g])
        );
    end

    dmx_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .views     (views),
        .ctl       (ctl),
        .cmd_valid (mem_cmd_valid),
        .cmd_ready (mem_cmd_ready),
        .cmd_write (mem_cmd_write),
        .cmd_addr  (mem_cmd_addr),
        .cmd_beats (mem_cmd_beats),
        .rvalid    (mem_rvalid),
        .wvalid    (mem_wvalid),
        .wready    (mem_wready),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx)
    );

    dmx_stage #(.WIDTH(DW), .DEPTH(BUF_WORDS)) u_stage (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (buf_idx),
        .wr_data (mem_rdata),
        .rd_idx  (buf_idx),
        .rd_data (mem_wdata)
    );

endmodule

// File: tb/sim_dma2ch_top.sv
module sim_dma2ch_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  req_i = '0;
    logic [1:0]  done_o;
    logic        mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
    logic [31:0] mem_cmd_addr;
    logic [3:0]  mem_cmd_beats;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_wvalid, mem_wready;
    logic [31:0] mem_wdata;

    always #2 clk = ~clk;  // 250 MHz

    dma2ch_top u0 (.*);

    // ---------------- behavioural memory ----------------
    logic [31:0] mem [256];
    int          ms = 0, left = 0, cyc = 0;
    logic [7:0]  ma = '0;
    logic        slow = 1'b0;
    logic        lw [64];
    logic [31:0] la [64];
    int          lb [64];
    int          ln = 0;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    int          hold_err = 0, stalls = 0;

    assign mem_cmd_ready = !rst && (ms == 0) && (!slow || cyc[0]);
    assign mem_wready    = (ms == 2) && (!slow || cyc[0]);

    initial begin
        forever begin
            @(posedge clk);
            cyc <= cyc + 1;
            if (rst) begin
                ms         <= 0;
                mem_rvalid <= 1'b0;
                hold_pend  <= 1'b0;
            end else begin
                if (hold_pend && (!mem_cmd_valid || mem_cmd_addr != hold_addr))
                    hold_err <= hold_err + 1;
                hold_pend <= mem_cmd_valid && !mem_cmd_ready;
                hold_addr <= mem_cmd_addr;
                if (mem_cmd_valid && !mem_cmd_ready)
                    stalls <= stalls + 1;
                case (ms)
                    0: begin
                        mem_rvalid <= 1'b0;
                        if (mem_cmd_valid && mem_cmd_ready) begin
                            if (ln < 64) begin
                                lw[ln] <= mem_cmd_write;
                                la[ln] <= mem_cmd_addr;
                                lb[ln] <= int'(mem_cmd_beats);
                            end
                            ln   <= ln + 1;
                            ma   <= mem_cmd_addr[9:2];
                            left <= int'(mem_cmd_beats);
                            ms   <= mem_cmd_write ? 2 : 1;
                        end
                    end
                    1: begin
                        if (left != 0) begin
                            mem_rvalid <= 1'b1;
                            mem_rdata  <= mem[ma];
                            ma         <= ma + 8'd1;
                            left       <= left - 1;
                        end else begin
                            mem_rvalid <= 1'b0;
                            ms         <= 0;
                        end
                    end
                    default: begin
                        if (mem_wvalid && mem_wready) begin
                            mem[ma] <= mem_wdata;
                            ma      <= ma + 8'd1;
                            left    <= left - 1;
                            if (left == 1)
                                ms <= 0;
                        end
                    end
                endcase
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input int rg, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'((ch << 2) | rg);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_req(input logic [1:0] m);
        @(negedge clk);
        req_i = m;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_done(input int ch, input string tag);
        int n = 0;
        while (!done_o[ch] && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done_o[ch] == 1'b1, tag, int'(done_o[ch]), 1);
    endtask

    task automatic fill(input int w0, input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) mem[w0 + i] = seed ^ (32'h01030507 * (i + 1));
    endtask

    task automatic same(input int sw, input int dw, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[dw + i] != mem[sw + i]) bad++;
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic cmd_is(input int k, input logic w, input int a, input int b, input string tag);
        check(lw[k] == w && la[k] == 32'(a) && lb[k] == b, tag,
              int'(la[k]) | (lb[k] << 24) | (int'(lw[k]) << 30), a | (b << 24) | (int'(w) << 30));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        check(done_o == 2'b00, "R8 done after reset", int'(done_o), 0);
        check(mem_cmd_valid == 1'b0, "R10 no command after reset", int'(mem_cmd_valid), 0);
    endtask

    task automatic t_sw_full;
        fill(0, 16, 32'h11110000);
        fill(128, 16, 32'hDEADBEEF);
        ln = 0;
        cfg(0, 0, 32'h000); cfg(0, 1, 32'h200); cfg(0, 2, 64);
        cfg(0, 3, 32'h3);
        wait_done(0, "R2 software start completes");
        check(ln == 4, "R4 four bursts for 64 bytes", ln, 4);
        cmd_is(0, 1'b0, 32'h000, 8, "R5 first read full");
        cmd_is(1, 1'b1, 32'h200, 8, "R4 drain follows fill");
        cmd_is(2, 1'b0, 32'h020, 8, "R6 source advanced");
        cmd_is(3, 1'b1, 32'h220, 8, "R6 destination advanced");
        same(0, 128, 16, "R4 copy matches");
        idle(20);
        check(done_o[0] == 1'b1, "R8 done is sticky", int'(done_o[0]), 1);
    endtask

    task automatic t_partial;
        slow = 1'b1;
        fill(64, 12, 32'h5A5A0000);
        fill(192, 12, 32'hCAFEF00D);
        ln = 0;
        cfg(1, 0, 32'h102); cfg(1, 1, 32'h301); cfg(1, 2, 46);
        cfg(1, 3, 32'h3);
        wait_done(1, "R5 partial transfer completes");
        check(ln == 4, "R5 two pairs for 44 bytes", ln, 4);
        cmd_is(0, 1'b0, 32'h100, 8, "R1 low source bits dropped");
        cmd_is(1, 1'b1, 32'h300, 8, "R1 low dest bits dropped");
        cmd_is(2, 1'b0, 32'h120, 3, "R5 tail read is 3 words");
        cmd_is(3, 1'b1, 32'h320, 3, "R5 tail write is 3 words");
        same(64, 192, 11, "R4 partial copy matches");
        check(mem[203] == (32'hCAFEF00D ^ (32'h01030507 * 12)), "R5 word past end untouched",
              int'(mem[203]), int'(32'hCAFEF00D ^ (32'h01030507 * 12)));
        slow = 1'b0;
    endtask

    task automatic t_go_no_en;
        cfg(1, 3, 32'h4);   // clear done, enable off
        ln = 0;
        cfg(1, 3, 32'h2);   // go without enable
        idle(40);
        check(ln == 0, "R2 go without enable has no traffic", ln, 0);
        check(done_o[1] == 1'b0, "R2 go without enable no done", int'(done_o[1]), 0);
    endtask

    task automatic t_req;
        fill(64, 8, 32'h77770000);
        fill(192, 8, 32'h0);
        cfg(1, 0, 32'h100); cfg(1, 1, 32'h300); cfg(1, 2, 32);
        ln = 0;
        pulse_req(2'b10);
        idle(40);
        check(ln == 0, "R3 request ignored while disabled", ln, 0);
        cfg(1, 3, 32'h1);
        pulse_req(2'b10);
        wait_done(1, "R3 request start completes");
        check(ln == 2, "R3 one pair issued", ln, 2);
        same(64, 192, 8, "R3 request copy matches");
    endtask

    task automatic t_clear_zero;
        cfg(0, 3, 32'h5);
        check(done_o[0] == 1'b0, "R8 done cleared by bit 2", int'(done_o[0]), 0);
        cfg(0, 2, 0);
        ln = 0;
        cfg(0, 3, 32'h3);
        idle(3);
        check(done_o[0] == 1'b1, "R8 zero count completes", int'(done_o[0]), 1);
        check(ln == 0, "R8 zero count no traffic", ln, 0);
    endtask

    task automatic t_priority;
        cfg(0, 3, 32'h5); cfg(1, 3, 32'h5);
        fill(0, 16, 32'h12340000);
        fill(64, 8, 32'h43210000);
        cfg(0, 0, 32'h000); cfg(0, 1, 32'h200); cfg(0, 2, 64);
        cfg(1, 0, 32'h100); cfg(1, 1, 32'h300); cfg(1, 2, 32);
        ln = 0;
        pulse_req(2'b11);
        wait_done(1, "R7 channel 1 completes");
        check(done_o[0] == 1'b1, "R7 channel 0 completes", int'(done_o[0]), 1);
        cmd_is(0, 1'b0, 32'h000, 8, "R7 channel 0 first");
        cmd_is(1, 1'b1, 32'h200, 8, "R7 owner keeps port for drain");
        cmd_is(2, 1'b0, 32'h020, 8, "R7 channel 0 re-wins");
        cmd_is(4, 1'b0, 32'h100, 8, "R7 channel 1 after channel 0");
        same(0, 128, 16, "R7 channel 0 data");
        same(64, 192, 8, "R7 channel 1 data");
    endtask

    task automatic t_busy;
        cfg(0, 3, 32'h5);
        slow = 1'b1;
        fill(0, 24, 32'h9E3779B9);
        fill(128, 24, 32'h0);
        cfg(0, 0, 32'h000); cfg(0, 1, 32'h200); cfg(0, 2, 96);
        ln = 0;
        cfg(0, 3, 32'h3);
        idle(4);
        cfg(0, 0, 32'h080);
        cfg(0, 2, 8);
        cfg(0, 3, 32'h0);
        wait_done(0, "R9 busy transfer completes");
        check(ln == 6, "R9 count write ignored", ln, 6);
        cmd_is(4, 1'b0, 32'h040, 8, "R9 source write ignored");
        same(0, 128, 24, "R9 copy intact");
        slow = 1'b0;
        cfg(0, 3, 32'h5);   // clear done, enable stays as it is written here
        cfg(0, 3, 32'h4);   // clear done with enable off
        cfg(0, 3, 32'h1);   // re-enable, idle
        cfg(0, 3, 32'h0);   // now disable (channel idle, accepted)
        ln = 0;
        pulse_req(2'b01);
        idle(20);
        check(done_o[0] == 1'b0, "R9 idle disable write taken", int'(done_o[0]), 0);
    endtask

    // ---------------- main ----------------
    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        idle(4);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        idle(2);
        t_sw_full();
        t_partial();
        t_go_no_en();
        t_req();
        t_clear_zero();
        t_priority();
        t_busy();
        check(stalls > 0, "R10 stalls were exercised", stalls, 1);
        check(hold_err == 0, "R10 command held until accepted", hold_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule